// File: doc/BRIEF.md
# DMA Request Handshake Unit

This unit sits between the external DMA pins of a chip and an internal transfer sequencer, and serves a parameterised number of channels (four by default). For each channel it synchronises the request pin and filters it for a minimum stable width. It then reads the request either as a trigger edge of selectable polarity or, in demand mode, as an active-high level. From that it issues a one-cycle start pulse to the sequencer. Once a channel has started, it refuses new edge requests until the transfer has finished.

While the sequencer performs accesses, the unit produces the active-low pin strobes from the sequencer's per-channel signals: an access-valid strobe, a last-access flag and a read/write phase bit. These strobes are an acknowledge for every external access, an end-of-process marker on the final access, and in fly-by mode an I/O read or I/O write strobe chosen by the transfer direction. All strobes are registered, so they appear one clock after the sequencer signals.

Each channel runs a three-state machine. CH_IDLE moves to CH_LAUNCH when the qualified trigger is present. CH_LAUNCH raises the start pulse and always moves to CH_BUSY on the next clock. CH_BUSY returns to CH_IDLE on the final access. A final access is an access with the last flag set that is either a fly-by access or the write phase of a two-cycle unit. Accesses are honoured only in CH_BUSY.

Top module: `dmahs_top`

## Requirements
- R1: After reset all strobe outputs (dack_n, deop_n, iord_n, iowr_n) are high and no start pulse is issued.
- R2: When cfg_pin_en of a channel is 0, its request pin is treated as low, and no pin activity produces a start pulse.
- R3: In edge mode (cfg_demand=0), a transition to the level selected by cfg_rise (1 = rising, 0 = falling) produces exactly one start pulse, one clock wide. A transition in the other direction produces none.
- R4: A new pin level is accepted only if it stays stable for at least STABLE_CYC (3) clocks after synchronisation. A pulse of 2 clocks produces no start, and a pulse of 3 clocks does.
- R5: After a start pulse, trigger edges on that channel are ignored until its final access has been seen. A trigger edge after that final access starts a new transfer.
- R6: In demand mode (cfg_demand=1), a high filtered level produces a start pulse. After each final access, another start pulse follows for as long as the level stays high. Once the level has dropped, no further start follows.
- R7: Each access (seq_acc=1) on a busy channel drives that channel's dack_n low for exactly the following clock.
- R8: deop_n goes low, one clock after the access, only for a final access: seq_last=1 together with either fly-by mode or the write phase (seq_wr=1). It stays high for all other accesses, including a read with seq_last=1 in two-cycle mode.
- R9: In fly-by mode (cfg_flyby=1), an access drives iord_n low when cfg_io2mem=1 and iowr_n low when cfg_io2mem=0. In two-cycle mode both stay high.
- R10: Channels are independent: simultaneous requests on two channels each yield one start pulse, and completing one channel leaves the other busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pin_en | input | NCH | Per-channel enable of the pin as request input |
| cfg_demand | input | NCH | 1 = demand (level) mode, 0 = edge mode |
| cfg_rise | input | NCH | Edge mode trigger: 1 = rising, 0 = falling |
| cfg_flyby | input | NCH | 1 = fly-by transfer, 0 = two-cycle transfer |
| cfg_io2mem | input | NCH | Fly-by direction: 1 = I/O to memory, 0 = memory to I/O |
| dreq_pin | input | NCH | Asynchronous request pins |
| seq_start | output | NCH | One-cycle start pulse to the sequencer |
| seq_acc | input | NCH | Sequencer access-valid strobe |
| seq_last | input | NCH | Access belongs to the last transfer unit |
| seq_wr | input | NCH | Phase: 1 = write, 0 = read |
| dack_n | output | NCH | Active-low access acknowledge |
| deop_n | output | NCH | Active-low end-of-process |
| iord_n | output | NCH | Active-low fly-by I/O read strobe |
| iowr_n | output | NCH | Active-low fly-by I/O write strobe |

## Verification
The bench builds the unit with NCH=4, SYNC_STAGES=2 and STABLE_CYC=3. These values let it drive each channel in a different configuration at the same time: edge rising, edge falling, demand, two-cycle, fly-by in both directions, and a disabled pin. With a threshold of three clocks, the accept/reject boundary lies between a 2-clock pulse and a 3-clock pulse, so a bench can place pulses on either side of it. Expected start pulses are queued per channel and matched against the observed pulses, so a missing or extra start in any scenario is reported.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_LAUNCH = 2'd1,
        CH_BUSY   = 2'd2
    } ch_state_e;

endpackage

// File: rtl/dmahs_sync.sv
module dmahs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dmahs_chan.sv
module dmahs_chan
    import dmahs_pkg::*;
#(
    parameter int STABLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_s,
    input  logic demand,
    input  logic rise_sel,
    input  logic fin,
    output logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(STABLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STABLE_CYC - 1);

    logic             filt;
    logic [CNT_W-1:0] cnt;
    logic             evt_rise, evt_fall;
    logic             trigger;
    ch_state_e        state_q, state_d;

    // stability filter: a new level must persist STABLE_CYC samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt     <= 1'b0;
            cnt      <= '0;
            evt_rise <= 1'b0;
            evt_fall <= 1'b0;
        end else begin
            evt_rise <= 1'b0;
            evt_fall <= 1'b0;
            if (level_s == filt) begin
                cnt <= '0;
            end else if (cnt == CNT_TOP) begin
                filt     <= level_s;
                cnt      <= '0;
                evt_rise <= level_s;
                evt_fall <= ~level_s;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign trigger = demand ? filt : (rise_sel ? evt_rise : evt_fall);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (trigger) state_d = CH_LAUNCH;
            end
            CH_LAUNCH: begin
                start   = 1'b1;
                state_d = CH_BUSY;
            end
            CH_BUSY: begin
                busy = 1'b1;
                if (fin) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end
endmodule

// File: rtl/dmahs_strobe.sv
module dmahs_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic acc,
    input  logic last,
    input  logic wr,
    input  logic flyby,
    input  logic io2mem,
    output logic fin,
    output logic dack_n,
    output logic deop_n,
    output logic iord_n,
    output logic iowr_n
);
    logic hit;

    assign hit = busy & acc;
    assign fin = hit & last & (flyby | wr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dack_n <= 1'b1;
            deop_n <= 1'b1;
            iord_n <= 1'b1;
            iowr_n <= 1'b1;
        end else begin
            dack_n <= ~hit;
            deop_n <= ~fin;
            iord_n <= ~(hit & flyby & io2mem);
            iowr_n <= ~(hit & flyby & ~io2mem);
        end
    end
endmodule

// File: rtl/dmahs_top.sv
module dmahs_top #(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CYC  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cfg_pin_en,
    input  logic [NCH-1:0] cfg_demand,
    input  logic [NCH-1:0] cfg_rise,
    input  logic [NCH-1:0] cfg_flyby,
    input  logic [NCH-1:0] cfg_io2mem,
    input  logic [NCH-1:0] dreq_pin,
    output logic [NCH-1:0] seq_start,
    input  logic [NCH-1:0] seq_acc,
    input  logic [NCH-1:0] seq_last,
    input  logic [NCH-1:0] seq_wr,
    output logic [NCH-1:0] dack_n,
    output logic [NCH-1:0] deop_n,
    output logic [NCH-1:0] iord_n,
    output logic [NCH-1:0] iowr_n
);
    logic [NCH-1:0] level_s, busy, fin;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmahs_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (dreq_pin[g] & cfg_pin_en[g]),
            .q     (level_s[g])
        );

        dmahs_chan #(.STABLE_CYC(STABLE_CYC)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_s  (level_s[g]),
            .demand   (cfg_demand[g]),
            .rise_sel (cfg_rise[g]),
            .fin      (fin[g]),
            .start    (seq_start[g]),
            .busy     (busy[g])
        );

        dmahs_strobe u_strobe (
            .clk    (clk),
            .rst_n  (rst_n),
            .busy   (busy[g]),
            .acc    (seq_acc[g]),
            .last   (seq_last[g]),
            .wr     (seq_wr[g]),
            .flyby  (cfg_flyby[g]),
            .io2mem (cfg_io2mem[g]),
            .fin    (fin[g]),
            .dack_n (dack_n[g]),
            .deop_n (deop_n[g]),
            .iord_n (iord_n[g]),
            .iowr_n (iowr_n[g])
        );
    end
endmodule

// File: rtl/dmahs_chk.sv
module dmahs_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] seq_start,
    input logic [NCH-1:0] seq_acc,
    input logic [NCH-1:0] dack_n,
    input logic [NCH-1:0] deop_n,
    input logic [NCH-1:0] iord_n,
    input logic [NCH-1:0] iowr_n
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R3
        start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seq_start[i] |=> !seq_start[i]);
        // R7
        dack_follows_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dack_n[i] |-> $past(seq_acc[i]));
        // R8
        deop_within_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !deop_n[i] |-> !dack_n[i]);
        // R9
        io_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !iord_n[i] |-> iowr_n[i]);
        // R9
        io_strobe_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!iord_n[i] || !iowr_n[i]) |-> !dack_n[i]);
        // R1
        reset_quiet_chk: assert property (@(posedge clk)
            !rst_n |=> (dack_n[i] && deop_n[i] && !seq_start[i]));
    end
endmodule

bind dmahs_top dmahs_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_start (seq_start),
    .seq_acc   (seq_acc),
    .dack_n    (dack_n),
    .deop_n    (deop_n),
    .iord_n    (iord_n),
    .iowr_n    (iowr_n)
);

// File: tb/dmahs_top_test.sv
module dmahs_top_test;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] cfg_pin_en = '1, cfg_demand = '0, cfg_rise = '1;
    logic [NCH-1:0] cfg_flyby = '0, cfg_io2mem = '0, dreq_pin = '0;
    logic [NCH-1:0] seq_acc = '0, seq_last = '0, seq_wr = '0;
    logic [NCH-1:0] seq_start, dack_n, deop_n, iord_n, iowr_n;

    int tests = 0, fails = 0;
    int exp_q[$];
    bit done = 0;

    always #4 clk = ~clk;

    dmahs_top #(.NCH(NCH), .SYNC_STAGES(2), .STABLE_CYC(3)) uut (.*);

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: every start pulse must match a queued expectation
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                if (seq_start[c]) begin
                    if (exp_q.size() == 0) chk("R3/R5 unexpected start on channel", c, -1);
                    else chk("R3 start channel", c, exp_q.pop_front());
                end
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int ch, int width, bit expect_start);
        if (expect_start) exp_q.push_back(ch);
        @(negedge clk) dreq_pin[ch] = ~dreq_pin[ch];
        cyc(width);
        dreq_pin[ch] = ~dreq_pin[ch];
        cyc(10);
    endtask

    task automatic expect_idle(string req);
        cyc(12);
        chk(req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic access(int ch, bit last, bit wr, bit e_dack, bit e_deop,
                          bit e_iord, bit e_iowr, string req);
        @(negedge clk);
        seq_acc[ch] = 1; seq_last[ch] = last; seq_wr[ch] = wr;
        @(negedge clk);
        chk({req, " dack_n"}, dack_n[ch], e_dack);
        chk({req, " deop_n"}, deop_n[ch], e_deop);
        chk({req, " iord_n"}, iord_n[ch], e_iord);
        chk({req, " iowr_n"}, iowr_n[ch], e_iowr);
        seq_acc[ch] = 0; seq_last[ch] = 0; seq_wr[ch] = 0;
        @(negedge clk);
        chk({req, " dack_n released"}, dack_n[ch], 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            chk("R1 dack_n", dack_n[c], 1);
            chk("R1 deop_n", deop_n[c], 1);
            chk("R1 iord_n", iord_n[c], 1);
            chk("R1 iowr_n", iowr_n[c], 1);
            chk("R1 seq_start", seq_start[c], 0);
        end
        rst_n = 1;
        cyc(3);

        // R2 disabled pin
        cfg_pin_en[2] = 0;
        pulse(2, 6, 0);
        expect_idle("R2 pending starts");
        cfg_pin_en[2] = 1;

        // R4 width threshold on channel 0 (rising)
        pulse(0, 2, 0);
        expect_idle("R4 short pulse");
        pulse(0, 3, 1);
        // R7 / R8 two-cycle unit accesses
        access(0, 0, 0, 0, 1, 1, 1, "R7 read");
        access(0, 0, 1, 0, 1, 1, 1, "R7 write");
        access(0, 1, 0, 0, 1, 1, 1, "R8 last read no deop");
        access(0, 1, 1, 0, 0, 1, 1, "R8 last write deop");
        expect_idle("R4 start seen");

        // R5 edges ignored while busy
        pulse(0, 5, 1);
        pulse(0, 5, 0);
        access(0, 1, 1, 0, 0, 1, 1, "R5 completion");
        expect_idle("R5 no stray start");
        pulse(0, 5, 1);
        access(0, 1, 1, 0, 0, 1, 1, "R5 rearmed completion");
        expect_idle("R5 rearm start");

        // R3 falling trigger, R9 fly-by I/O to memory on channel 1
        cfg_rise[1] = 0; cfg_flyby[1] = 1; cfg_io2mem[1] = 1;
        @(negedge clk) dreq_pin[1] = 1;
        cyc(10);
        expect_idle("R3 opposite edge ignored");
        exp_q.push_back(1);
        dreq_pin[1] = 0;
        cyc(10);
        access(1, 0, 0, 0, 1, 0, 1, "R9 iord");
        access(1, 1, 0, 0, 0, 0, 1, "R8 flyby last");
        expect_idle("R3 falling start");

        // R9 fly-by memory to I/O on channel 3
        cfg_flyby[3] = 1; cfg_io2mem[3] = 0;
        pulse(3, 4, 1);
        access(3, 1, 1, 0, 0, 1, 0, "R9 iowr");
        expect_idle("R9 start");

        // R6 demand mode on channel 2
        cfg_demand[2] = 1;
        exp_q.push_back(2);
        @(negedge clk) dreq_pin[2] = 1;
        cyc(10);
        exp_q.push_back(2);
        access(2, 1, 1, 0, 0, 1, 1, "R6 unit 1");
        cyc(6);
        chk("R6 second start", exp_q.size(), 0);
        dreq_pin[2] = 0;
        cyc(10);
        access(2, 1, 1, 0, 0, 1, 1, "R6 unit 2");
        expect_idle("R6 stops after level drop");
        cfg_demand[2] = 0;

        // R10 simultaneous channels 0 and 3
        exp_q.push_back(0); exp_q.push_back(3);
        @(negedge clk) begin dreq_pin[0] = 1; dreq_pin[3] = 1; end
        cyc(4);
        dreq_pin[0] = 0; dreq_pin[3] = 0;
        cyc(10);
        chk("R10 both started", exp_q.size(), 0);
        access(0, 1, 1, 0, 0, 1, 1, "R10 ch0 done");
        access(3, 0, 0, 0, 1, 1, 0, "R10 ch3 still busy");
        access(3, 1, 1, 0, 0, 1, 0, "R10 ch3 done");
        expect_idle("R10 no extra start");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule